// File: doc/BRIEF.md
# Pipelined Bus Memory Target with Wait States

This block is a 32-bit target on a single-initiator pipelined AHB-Lite style bus, backed by a small register file. An address phase is taken on a rising clock edge only while the bus ready input is high and the transfer type marks a real access. The access itself runs in the data phase that follows: the target holds its ready output low for a fixed number of wait states, then completes the read or write. Sub-word writes touch only the addressed byte lanes. An access beyond the end of the register file is refused with a two-cycle error response.

A state machine orders the data phase. The states are ST_IDLE (no data phase, ready high, OKAY), ST_WAIT (counting wait states, ready low), ST_ACCESS (last data-phase cycle, ready high; read data driven, write committed at the closing edge), ST_ERR1 (error first cycle, ready low) and ST_ERR2 (error second cycle, ready high). Transitions: from ST_IDLE, ST_ACCESS or ST_ERR2, a captured real transfer goes to ST_ERR1 when out of range, else to ST_WAIT when the wait count is non-zero, else to ST_ACCESS; with no capture these three states go to ST_IDLE. ST_WAIT moves to ST_ACCESS once its counter reaches zero. ST_ERR1 always moves to ST_ERR2. Reset forces ST_IDLE from any state.

Top module: `ahbm_slave`

## Requirements
- R1: While reset (active low, asynchronous) is asserted and on the first cycle after it, ready out is 1, the response is 0 and read data is zero; reset drops any pending transfer and clears every stored word to zero.
- R2: An address phase is captured only on a rising edge where ready in is 1 and the transfer type is NONSEQ (2'b10) or SEQ (2'b11); an address phase presented while ready in is 0 has no effect on outputs or memory.
- R3: IDLE (2'b00) and BUSY (2'b01) transfers give a following cycle with ready out 1 and response 0, and leave memory unchanged even when the write flag is set.
- R4: Every in-range real transfer holds ready out at 0 for exactly WAIT_STATES data-phase cycles (parameter, 0 to 3), then raises it for one completing cycle.
- R5: Read data carries the whole addressed 32-bit word in the cycle where ready out returns to 1 for an in-range read; in every other cycle it is zero.
- R6: Write data is taken in the data phase, one cycle or more after its address phase, and stored at the edge that ends the completing cycle.
- R7: Size selects the written lanes, lane k being bits 8k+7 down to 8k: size 0 writes the one lane given by address bits 1:0, size 1 writes lanes 0-1 or 2-3 chosen by address bit 1, size 2 or above writes all four; other lanes keep their contents.
- R8: The response is 0 (OKAY) in every cycle of an in-range transfer and whenever no transfer is in its data phase.
- R9: A real transfer at a byte address of MEM_WORDS*4 or above gets response 1 with ready 0 for one cycle, then response 1 with ready 1, with no wait states, no memory change and zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the address phase |
| bus_trans | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_size | input | 3 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | DATA_W | Write data, valid in the data phase |
| bus_ready_in | input | 1 | Bus-level ready; address phase accepted when high |
| bus_rdata | output | DATA_W | Read data, valid when ready out completes a read |
| bus_ready_out | output | 1 | Target ready; low stretches the data phase |
| bus_resp | output | 1 | Response: 0 OKAY, 1 ERROR |

## Verification
The bench goes after lane placement with byte and halfword writes at every offset class, where a design mixing up lane order or address bits would corrupt neighbouring bytes of a word read back whole. It writes just past the top of the store and then reads word zero, catching a design that truncates the address and aliases the refused write into memory. It drives BUSY and IDLE phases with the write flag set, and a real write while bus ready is held low, both of which a careless design would commit. It counts wait cycles on every access and cuts reset into a stretched data phase, exposing a counter that runs one short or long or a state that survives reset.

// File: rtl/ahbm_pkg.sv
package ahbm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ACCESS,
        ST_ERR1,
        ST_ERR2
    } ahbm_state_t;

    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    localparam logic [2:0] SZ_BYTE = 3'd0;
    localparam logic [2:0] SZ_HALF = 3'd1;
    localparam logic [2:0] SZ_WORD = 3'd2;

endpackage

// File: rtl/ahbm_addr_stage.sv
module ahbm_addr_stage #(
    parameter int OFF_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [OFF_W-1:0] in_off,
    input  logic             in_write,
    input  logic [2:0]       in_size,
    output logic [OFF_W-1:0] q_off,
    output logic             q_write,
    output logic [2:0]       q_size
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_off   <= '0;
            q_write <= 1'b0;
            q_size  <= '0;
        end else if (load) begin
            q_off   <= in_off;
            q_write <= in_write;
            q_size  <= in_size;
        end
    end

endmodule

// File: rtl/ahbm_lane_gen.sv
module ahbm_lane_gen #(
    parameter int DATA_W = 32
) (
    input  logic [2:0]                      size,
    input  logic [$clog2(DATA_W/8)-1:0]     lo,
    output logic [DATA_W/8-1:0]             lane_en
);

    localparam int LANES = DATA_W / 8;
    localparam int LB    = $clog2(LANES);

    always_comb begin
        int span;
        logic [LB-1:0] keep;
        span = (int'(size) >= LB) ? LANES : (1 << size);
        keep = ~LB'(span - 1);
        for (int k = 0; k < LANES; k++) begin
            lane_en[k] = ((LB'(k) & keep) == (lo & keep));
        end
    end

endmodule

// File: rtl/ahbm_store.sv
module ahbm_store #(
    parameter int WORDS  = 16,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DATA_W/8-1:0]        wr_lanes,
    input  logic [$clog2(WORDS)-1:0]   wr_idx,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [$clog2(WORDS)-1:0]   rd_idx,
    output logic [DATA_W-1:0]          rd_data
);

    localparam int LANES = DATA_W / 8;

    logic [7:0] cells [WORDS][LANES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) begin
                for (int l = 0; l < LANES; l++) begin
                    cells[w][l] <= 8'h00;
                end
            end
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (wr_lanes[l]) begin
                    cells[wr_idx][l] <= wr_data[l*8 +: 8];
                end
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_rd_lane
        assign rd_data[g*8 +: 8] = cells[rd_idx][g];
    end

endmodule

// File: rtl/ahbm_slave.sv
module ahbm_slave #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int MEM_WORDS   = 16,
    parameter int WAIT_STATES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_trans,
    input  logic              bus_write,
    input  logic [2:0]        bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready_in,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready_out,
    output logic              bus_resp
);

    import ahbm_pkg::*;

    localparam int LANES     = DATA_W / 8;
    localparam int LB        = $clog2(LANES);
    localparam int IDX_W     = $clog2(MEM_WORDS);
    localparam int OFF_W     = IDX_W + LB;
    localparam int MEM_BYTES = MEM_WORDS * LANES;
    localparam int CNT_W     = (WAIT_STATES > 1) ? $clog2(WAIT_STATES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD =
        CNT_W'((WAIT_STATES > 0) ? WAIT_STATES - 1 : 0);

    ahbm_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    logic             real_xfer;
    logic             open_slot;
    logic             take;
    logic             in_range;

    logic [OFF_W-1:0] q_off;
    logic             q_write;
    logic [2:0]       q_size;

    logic [LANES-1:0] lane_en;
    logic [LANES-1:0] wr_lanes;
    logic [DATA_W-1:0] word_rd;

    logic             drive_rd;
    logic             do_wr;

    assign real_xfer = (bus_trans == TR_NONSEQ) || (bus_trans == TR_SEQ);
    assign open_slot = (state_q == ST_IDLE) || (state_q == ST_ACCESS) ||
                       (state_q == ST_ERR2);
    assign take      = open_slot && bus_ready_in && real_xfer;
    assign in_range  = bus_addr < ADDR_W'(MEM_BYTES);

    ahbm_addr_stage #(.OFF_W(OFF_W)) u_addr_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take),
        .in_off   (bus_addr[OFF_W-1:0]),
        .in_write (bus_write),
        .in_size  (bus_size),
        .q_off    (q_off),
        .q_write  (q_write),
        .q_size   (q_size)
    );

    ahbm_lane_gen #(.DATA_W(DATA_W)) u_lane_gen (
        .size    (q_size),
        .lo      (q_off[LB-1:0]),
        .lane_en (lane_en)
    );

    assign wr_lanes = do_wr ? lane_en : '0;

    ahbm_store #(.WORDS(MEM_WORDS), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_lanes (wr_lanes),
        .wr_idx   (q_off[OFF_W-1:LB]),
        .wr_data  (bus_wdata),
        .rd_idx   (q_off[OFF_W-1:LB]),
        .rd_data  (word_rd)
    );

    // State register and wait counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                cnt_q <= CNT_LOAD;
            end else if (state_q == ST_WAIT && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_ACCESS, ST_ERR2: begin
                if (take) begin
                    if (!in_range) begin
                        state_d = ST_ERR1;
                    end else if (WAIT_STATES > 0) begin
                        state_d = ST_WAIT;
                    end else begin
                        state_d = ST_ACCESS;
                    end
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_WAIT: begin
                if (cnt_q == '0) begin
                    state_d = ST_ACCESS;
                end
            end
            ST_ERR1: state_d = ST_ERR2;
            default: state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        bus_ready_out = 1'b1;
        bus_resp      = 1'b0;
        drive_rd      = 1'b0;
        do_wr         = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WAIT: bus_ready_out = 1'b0;
            ST_ACCESS: begin
                drive_rd = !q_write;
                do_wr    = q_write;
            end
            ST_ERR1: begin
                bus_ready_out = 1'b0;
                bus_resp      = 1'b1;
            end
            ST_ERR2: bus_resp = 1'b1;
            default: ;
        endcase
    end

    assign bus_rdata = drive_rd ? word_rd : '0;

endmodule

// File: rtl/ahbm_checker.sv
module ahbm_checker #(
    parameter int DATA_W      = 32,
    parameter int WAIT_STATES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        bus_trans,
    input logic              bus_ready_in,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_ready_out,
    input logic              bus_resp
);

    logic [3:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (!bus_ready_out && !bus_resp) begin
            low_run <= low_run + 1'b1;
        end else begin
            low_run <= '0;
        end
    end

    assert_reset_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (bus_ready_out && !bus_resp));

    assert_idle_busy_okay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready_in && bus_ready_out && !bus_trans[1]) |=> (bus_ready_out && !bus_resp));

    assert_wait_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ready_out && !bus_resp) |-> (low_run < 4'(WAIT_STATES)));

    assert_rdata_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready_out |-> (bus_rdata == '0));

    assert_err_second_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_resp && !bus_ready_out) |=> (bus_resp && bus_ready_out));

    assert_err_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_resp && bus_ready_out) |-> $past(bus_resp && !bus_ready_out));

endmodule

bind ahbm_slave ahbm_checker #(
    .DATA_W      (DATA_W),
    .WAIT_STATES (WAIT_STATES)
) u_ahbm_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_trans     (bus_trans),
    .bus_ready_in  (bus_ready_in),
    .bus_rdata     (bus_rdata),
    .bus_ready_out (bus_ready_out),
    .bus_resp      (bus_resp)
);

// File: tb/ahbm_slave_bench.sv
module ahbm_slave_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WS         = 2;
    localparam int NVEC       = 16;

    typedef struct packed {
        logic        wr;
        logic [1:0]  tr;
        logic [2:0]  size;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp_rd;
        logic        exp_err;
    } vec_t;

    // R1 memory clear, R6/R7 lanes, R8 okay, R9 error and no aliasing
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 2'b10, 3'd2, 32'h10, 32'h0,        32'h0,        1'b0},
        '{1'b1, 2'b10, 3'd2, 32'h00, 32'hA1B2C3D4, 32'h0,        1'b0},
        '{1'b0, 2'b10, 3'd2, 32'h00, 32'h0,        32'hA1B2C3D4, 1'b0},
        '{1'b1, 2'b11, 3'd0, 32'h05, 32'h00005A00, 32'h0,        1'b0},
        '{1'b0, 2'b10, 3'd2, 32'h04, 32'h0,        32'h00005A00, 1'b0},
        '{1'b1, 2'b10, 3'd1, 32'h0A, 32'hBEEF0000, 32'h0,        1'b0},
        '{1'b0, 2'b11, 3'd2, 32'h08, 32'h0,        32'hBEEF0000, 1'b0},
        '{1'b1, 2'b10, 3'd0, 32'h03, 32'h11223344, 32'h0,        1'b0},
        '{1'b0, 2'b10, 3'd2, 32'h00, 32'h0,        32'h11B2C3D4, 1'b0},
        '{1'b1, 2'b10, 3'd1, 32'h00, 32'hFFFF7777, 32'h0,        1'b0},
        '{1'b0, 2'b10, 3'd0, 32'h01, 32'h0,        32'h11B27777, 1'b0},
        '{1'b1, 2'b10, 3'd2, 32'h3C, 32'hCAFEF00D, 32'h0,        1'b0},
        '{1'b0, 2'b10, 3'd2, 32'h3C, 32'h0,        32'hCAFEF00D, 1'b0},
        '{1'b1, 2'b10, 3'd2, 32'h40, 32'hDEADBEEF, 32'h0,        1'b1},
        '{1'b0, 2'b11, 3'd2, 32'h44, 32'h0,        32'h0,        1'b1},
        '{1'b0, 2'b10, 3'd2, 32'h00, 32'h0,        32'h11B27777, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [1:0]  bus_trans = 2'b00;
    logic        bus_write = 1'b0;
    logic [2:0]  bus_size = 3'd2;
    logic [31:0] bus_wdata = '0;
    logic        hold_low = 1'b0;
    logic        bus_ready_in;
    logic [31:0] bus_rdata;
    logic        bus_ready_out;
    logic        bus_resp;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    assign bus_ready_in = hold_low ? 1'b0 : bus_ready_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    ahbm_slave #(.WAIT_STATES(WS)) u_ahbm_slave (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr      (bus_addr),
        .bus_trans     (bus_trans),
        .bus_write     (bus_write),
        .bus_size      (bus_size),
        .bus_wdata     (bus_wdata),
        .bus_ready_in  (bus_ready_in),
        .bus_rdata     (bus_rdata),
        .bus_ready_out (bus_ready_out),
        .bus_resp      (bus_resp)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One non-overlapped transfer; returns at the negedge of the completing cycle
    task automatic xfer(input logic wr, input logic [1:0] tr, input logic [2:0] size,
                        input logic [31:0] addr, input logic [31:0] wdata,
                        output logic [31:0] rd, output logic resp_first,
                        output logic resp_last, output int waits);
        @(negedge clk);
        bus_trans = tr;
        bus_addr  = addr;
        bus_write = wr;
        bus_size  = size;
        @(posedge clk);
        @(negedge clk);
        bus_trans  = 2'b00;
        bus_wdata  = wdata;
        waits      = 0;
        resp_first = bus_resp;
        while (!bus_ready_out) begin
            waits++;
            @(negedge clk);
        end
        rd        = bus_rdata;
        resp_last = bus_resp;
    endtask

    initial begin
        logic [31:0] rd;
        logic        rf, rl;
        int          w;

        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk("R1 ready in reset", 32'(bus_ready_out), 32'd1);
        chk("R1 resp in reset", 32'(bus_resp), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", 32'(bus_ready_out), 32'd1);
        chk("R1 rdata after reset", bus_rdata, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            xfer(VECS[i].wr, VECS[i].tr, VECS[i].size, VECS[i].addr, VECS[i].wdata,
                 rd, rf, rl, w);
            if (VECS[i].exp_err) begin
                chk("R9 first cycle error", 32'(rf), 32'd1);
                chk("R9 second cycle error", 32'(rl), 32'd1);
                chk("R9 one low cycle", 32'(w), 32'd1);
                chk("R9 rdata zero", rd, 32'h0);
            end else begin
                chk("R8 okay response", 32'(rl), 32'd0);
                chk("R4 wait count", 32'(w), 32'(WS));
                if (!VECS[i].wr) begin
                    chk("R5 R7 read data", rd, VECS[i].exp_rd);
                end
            end
        end

        // R3: BUSY and IDLE with write flag set leave memory alone
        @(negedge clk);
        bus_trans = 2'b01; bus_write = 1'b1; bus_size = 3'd2; bus_addr = 32'h0;
        @(posedge clk);
        @(negedge clk);
        bus_wdata = 32'h0BAD0BAD;
        chk("R3 busy ready", 32'(bus_ready_out), 32'd1);
        chk("R3 busy okay", 32'(bus_resp), 32'd0);
        bus_trans = 2'b00;
        @(posedge clk);
        @(negedge clk);
        chk("R3 idle ready", 32'(bus_ready_out), 32'd1);
        xfer(1'b0, 2'b10, 3'd2, 32'h0, 32'h0, rd, rf, rl, w);
        chk("R3 memory unchanged", rd, 32'h11B27777);

        // R2: address phase with bus ready low is not taken
        @(negedge clk);
        hold_low = 1'b1;
        bus_trans = 2'b10; bus_write = 1'b1; bus_size = 3'd2; bus_addr = 32'h04;
        @(posedge clk);
        @(negedge clk);
        hold_low = 1'b0;
        bus_trans = 2'b00;
        bus_wdata = 32'hFFFFFFFF;
        chk("R2 no data phase started", 32'(bus_ready_out), 32'd1);
        xfer(1'b0, 2'b10, 3'd2, 32'h04, 32'h0, rd, rf, rl, w);
        chk("R2 memory unchanged", rd, 32'h00005A00);

        // R1: reset inside a stretched data phase
        @(negedge clk);
        bus_trans = 2'b10; bus_write = 1'b0; bus_addr = 32'h08;
        @(posedge clk);
        @(negedge clk);
        bus_trans = 2'b00;
        chk("R4 stretched before reset", 32'(bus_ready_out), 32'd0);
        rst_n = 1'b0;
        #1;
        chk("R1 ready on reset", 32'(bus_ready_out), 32'd1);
        chk("R1 resp on reset", 32'(bus_resp), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        xfer(1'b0, 2'b10, 3'd2, 32'h08, 32'h0, rd, rf, rl, w);
        chk("R1 memory cleared", rd, 32'h0);
        chk("R1 no stale transfer", 32'(w), 32'(WS));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule